// File: doc/BRIEF.md
# Paged Register Access Decoder with DMA Path

This block turns the cycles of an 8-bit CPU port into register reads and writes for a bus-interface controller. A 3-bit select chooses one of eight offsets while chip enable, a write strobe and a read strobe qualify the cycle. Offset 0 reaches the data-in byte on a read and the data-out byte on a write. Offset 3 takes auxiliary commands on a write and returns the last command on a read. The other offsets are plain storage.

A small bank of four page registers shares offsets with the storage. A page-in auxiliary command (code `0x50 | k`, k in 0..3, written at offset 3) makes one of them visible, under one of two policies chosen by `page_mode`. In sticky mode (`page_mode`=0), page register k replaces offset 2 until a later page-in or a reset. In one-shot mode (`page_mode`=1), the page bank overlays offsets 4..7 (page register n at offset 4+n) for the next CPU access only, and k is not used. A DMA grant bypasses the select: it routes the cycle to the data bytes and flips the sense of the read strobe. A registered request output asks for such grant cycles.

Top module: `paged_reg_port`

## Requirements
- R1: A CPU write (`cs`=1, `wr_en`=1) at offset 1, 4..7 or an unpaged offset 2 stores `wdata`. A CPU read (`cs`=1, `rd_en`=1) loads that offset's value onto `rdata` after the clock edge of the read. `rdata` holds its value between reads, and storage reads 0 after reset.
- R2: A CPU read at offset 0 returns the data-in byte and clears `din_full`. A CPU write at offset 0 puts `wdata` on `dout_byte` and sets `dout_full`.
- R3: With `page_mode`=0, writing `0x50|k` at offset 3 maps page register k at offset 2 for both reads and writes. With `page_mode`=1, the same command leaves the offset 2 mapping unchanged.
- R4: A sticky mapping survives any number of other accesses and is replaced only by a later page-in.
- R5: With `page_mode`=1, a page-in command arms a window. In the next CPU access, offsets 4..7 reach page registers 0..3. The window closes at the end of that access, whatever its offset. DMA cycles and idle cycles neither use nor close the window.
- R6: With `dma_gnt`=1, `wr_en`=1 writes `wdata` to the data-out byte, and `wr_en`=0 with `rd_en`=0 reads the data-in byte onto `rdata` and clears `din_full`. `reg_sel` and `cs` are ignored.
- R7: With `dma_gnt`=1, `wr_en`=0 and `rd_en`=1, no access takes place.
- R8: `dma_req` is registered. It is high after an edge that leaves the data-in byte full or the data-out byte empty. It is low after an edge that completed a grant cycle.
- R9: A cycle with `cs`=0 and `dma_gnt`=0 changes no register and no page state.
- R10: Reset clears all mappings, the armed window, storage, `rdata`, both full flags and `dma_req`.
- R11: In a CPU cycle with both strobes high, the write is performed and the read is not.
- R12: A CPU read at offset 3 returns the last byte written there, whether or not it was a page-in code.
- R13: `rx_load` loads `rx_byte` and sets `din_full`. When a read of the data-in byte falls in the same cycle, the read returns the old byte and `din_full` stays set. `tx_take` clears `dout_full` unless a data-out write falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_mode | input | 1 | 0 = sticky paging at offset 2, 1 = one-shot window at offsets 4..7 |
| cs | input | 1 | Chip enable for CPU cycles, active high |
| wr_en | input | 1 | Write strobe, active high |
| rd_en | input | 1 | Read strobe: active high for CPU cycles, active low for grant cycles |
| reg_sel | input | 3 | Register offset |
| wdata | input | 8 | Write data from the CPU or DMA |
| rdata | output | 8 | Registered read data |
| dma_gnt | input | 1 | DMA grant; selects the data bytes directly |
| dma_req | output | 1 | DMA request |
| rx_load | input | 1 | Bus side loads a received byte |
| rx_byte | input | 8 | Received byte |
| din_full | output | 1 | Data-in byte not yet read |
| tx_take | input | 1 | Bus side consumes the data-out byte |
| dout_byte | output | 8 | Data-out byte |
| dout_full | output | 1 | Data-out byte waiting to be sent |

## Verification
A corrupted page state shows up on the first read of offset 2 or offsets 4..7. That read returns the value of the other storage bank on `rdata` one cycle after the strobe. A one-shot window that fails to close leaks the same kind of wrong value into the access after next. A stale full flag or request shows on `dma_req` within one edge, because the request is computed from the next-state flags. The bench therefore writes distinct values into the storage and page banks before it reads them back, so that each mis-mapping gives a visible byte mismatch.

// File: rtl/prp_pkg.sv
package prp_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int NREG   = 1 << SEL_W;
    localparam int NPAGE  = 4;
    localparam int PAGE_W = $clog2(NPAGE);

    // page-in command: fixed upper bits, page index in the low bits
    localparam logic [DATA_W-1:0] PAGE_IDX_MASK = DATA_W'(NPAGE - 1);
    localparam logic [DATA_W-1:0] PAGE_CMD      = 8'h50;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic             dma;
        logic [SEL_W-1:0] sel;
    } acc_t;

    typedef struct packed {
        logic              vld;
        logic [PAGE_W-1:0] idx;
        logic              armed;
    } page_st_t;

    typedef struct packed {
        logic [DATA_W-1:0] din;
        logic              din_full;
        logic [DATA_W-1:0] dout;
        logic              dout_full;
        logic              req;
    } data_st_t;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0]  gen;
        logic [NPAGE-1:0][DATA_W-1:0] pg;
        logic [DATA_W-1:0]            rdata;
    } file_st_t;
endpackage

// File: rtl/prp_cycle_decode.sv
module prp_cycle_decode
    import prp_pkg::*;
#(
    parameter int DIN_OFFSET = 0
) (
    input  logic             cs,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             dma_gnt,
    input  logic [SEL_W-1:0] reg_sel,
    output acc_t             acc
);
    always_comb begin
        acc.kind = ACC_NONE;
        acc.dma  = 1'b0;
        acc.sel  = reg_sel;
        if (dma_gnt) begin
            // grant: select forced to the data bytes, read strobe inverted
            acc.dma = 1'b1;
            acc.sel = SEL_W'(DIN_OFFSET);
            if (wr_en)       acc.kind = ACC_WR;
            else if (!rd_en) acc.kind = ACC_RD;
        end else if (cs) begin
            if (wr_en)      acc.kind = ACC_WR;
            else if (rd_en) acc.kind = ACC_RD;
        end
    end
endmodule

// File: rtl/prp_page_map.sv
module prp_page_map
    import prp_pkg::*;
#(
    parameter int PG_OFFSET  = 2,
    parameter int WIN_BASE   = 4,
    parameter int CMD_OFFSET = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_mode,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic              page_hit,
    output logic [PAGE_W-1:0] page_idx,
    output logic              page_cmd,
    output logic              sticky_vld,
    output logic [PAGE_W-1:0] sticky_idx,
    output logic              armed
);
    page_st_t          st_d, st_q;
    logic              cpu_acc;
    logic [NPAGE-1:0]  win_match;

    assign cpu_acc  = (acc.kind != ACC_NONE) && !acc.dma;
    assign page_cmd = (acc.kind == ACC_WR) && !acc.dma
                   && (acc.sel == SEL_W'(CMD_OFFSET))
                   && ((wdata & ~PAGE_IDX_MASK) == PAGE_CMD);

    // one comparator per window slot
    for (genvar i = 0; i < NPAGE; i++) begin : g_win
        assign win_match[i] = st_q.armed && !acc.dma
                           && (acc.sel == SEL_W'(WIN_BASE + i));
    end

    always_comb begin
        page_hit = 1'b0;
        page_idx = '0;
        if (st_q.vld && !acc.dma && acc.sel == SEL_W'(PG_OFFSET)) begin
            page_hit = 1'b1;
            page_idx = st_q.idx;
        end else begin
            for (int i = 0; i < NPAGE; i++) begin
                if (win_match[i]) begin
                    page_hit = 1'b1;
                    page_idx = PAGE_W'(i);
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (cpu_acc) st_d.armed = 1'b0;
        if (page_cmd) begin
            if (page_mode) begin
                st_d.armed = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.idx = wdata[PAGE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky_vld = st_q.vld;
    assign sticky_idx = st_q.idx;
    assign armed      = st_q.armed;
endmodule

// File: rtl/prp_data_regs.sv
module prp_data_regs
    import prp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic              is_dma,
    input  logic              data_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_take,
    output logic [DATA_W-1:0] din_byte,
    output logic              din_full,
    output logic [DATA_W-1:0] dout_byte,
    output logic              dout_full,
    output logic              dma_req
);
    data_st_t dq_d, dq_q;
    logic     rd_hit, wr_hit, gnt_done;

    assign rd_hit   = data_sel && (kind == ACC_RD);
    assign wr_hit   = data_sel && (kind == ACC_WR);
    assign gnt_done = is_dma && (kind != ACC_NONE);

    always_comb begin
        dq_d = dq_q;
        if (rx_load) begin
            dq_d.din      = rx_byte;
            dq_d.din_full = 1'b1;
        end else if (rd_hit) begin
            dq_d.din_full = 1'b0;
        end
        if (wr_hit) begin
            dq_d.dout      = wdata;
            dq_d.dout_full = 1'b1;
        end else if (tx_take) begin
            dq_d.dout_full = 1'b0;
        end
        dq_d.req = (dq_d.din_full || !dq_d.dout_full) && !gnt_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dq_q <= '0;
        else        dq_q <= dq_d;
    end

    assign din_byte  = dq_q.din;
    assign din_full  = dq_q.din_full;
    assign dout_byte = dq_q.dout;
    assign dout_full = dq_q.dout_full;
    assign dma_req   = dq_q.req;
endmodule

// File: rtl/paged_reg_port.sv
module paged_reg_port
    import prp_pkg::*;
#(
    parameter int DIN_OFFSET = 0,
    parameter int PG_OFFSET  = 2,
    parameter int CMD_OFFSET = 3,
    parameter int WIN_BASE   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_mode,
    input  logic              cs,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              dma_gnt,
    output logic              dma_req,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              din_full,
    input  logic              tx_take,
    output logic [DATA_W-1:0] dout_byte,
    output logic              dout_full
);
    acc_t              acc;
    logic              page_hit, page_cmd, sticky_vld, armed, data_sel;
    logic [PAGE_W-1:0] page_idx, sticky_idx;
    logic [DATA_W-1:0] din_byte;
    file_st_t          file_d, file_q;

    prp_cycle_decode #(.DIN_OFFSET(DIN_OFFSET)) i_dec (
        .cs      (cs),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .dma_gnt (dma_gnt),
        .reg_sel (reg_sel),
        .acc     (acc)
    );

    prp_page_map #(
        .PG_OFFSET  (PG_OFFSET),
        .WIN_BASE   (WIN_BASE),
        .CMD_OFFSET (CMD_OFFSET)
    ) i_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_mode  (page_mode),
        .acc        (acc),
        .wdata      (wdata),
        .page_hit   (page_hit),
        .page_idx   (page_idx),
        .page_cmd   (page_cmd),
        .sticky_vld (sticky_vld),
        .sticky_idx (sticky_idx),
        .armed      (armed)
    );

    assign data_sel = (acc.sel == SEL_W'(DIN_OFFSET)) && !page_hit;

    prp_data_regs i_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (acc.kind),
        .is_dma    (acc.dma),
        .data_sel  (data_sel),
        .wdata     (wdata),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .tx_take   (tx_take),
        .din_byte  (din_byte),
        .din_full  (din_full),
        .dout_byte (dout_byte),
        .dout_full (dout_full),
        .dma_req   (dma_req)
    );

    always_comb begin
        file_d = file_q;
        if (acc.kind == ACC_WR) begin
            if (page_hit)      file_d.pg[page_idx] = wdata;
            else if (!data_sel) file_d.gen[acc.sel] = wdata;
        end else if (acc.kind == ACC_RD) begin
            if (page_hit)      file_d.rdata = file_q.pg[page_idx];
            else if (data_sel) file_d.rdata = din_byte;
            else               file_d.rdata = file_q.gen[acc.sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) file_q <= '0;
        else        file_q <= file_d;
    end

    assign rdata = file_q.rdata;
endmodule

// File: rtl/prp_checker.sv
module prp_checker
    import prp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wr_en,
    input logic              rd_en,
    input logic              dma_gnt,
    input logic              dma_req,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] din_byte,
    input logic              sticky_vld,
    input logic [PAGE_W-1:0] sticky_idx,
    input logic              armed,
    input logic              page_cmd
);
    p_gnt_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && (wr_en || !rd_en)) |=> !dma_req);

    p_dma_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && !wr_en && !rd_en) |=> (rdata == $past(din_byte)));

    p_gnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && !wr_en && rd_en) |=> $stable(rdata));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !dma_gnt) |=> ($stable(rdata) && $stable(sticky_vld)
                               && $stable(sticky_idx) && $stable(armed)));

    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !page_cmd |=> ($stable(sticky_vld) && $stable(sticky_idx)));

    p_window_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cs && !dma_gnt && (wr_en || rd_en) && !page_cmd) |=> !armed);
endmodule

bind paged_reg_port prp_checker i_prp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .dma_gnt    (dma_gnt),
    .dma_req    (dma_req),
    .rdata      (rdata),
    .din_byte   (din_byte),
    .sticky_vld (sticky_vld),
    .sticky_idx (sticky_idx),
    .armed      (armed),
    .page_cmd   (page_cmd)
);

// File: tb/test_paged_reg_port.sv
module test_paged_reg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       page_mode = 1'b0;
    logic       cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0, dma_gnt = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       dma_req, din_full, dout_full;
    logic       rx_load = 1'b0, tx_take = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [7:0] dout_byte;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    paged_reg_port i_paged_reg_port (
        .clk(clk), .rst_n(rst_n), .page_mode(page_mode), .cs(cs),
        .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel), .wdata(wdata),
        .rdata(rdata), .dma_gnt(dma_gnt), .dma_req(dma_req),
        .rx_load(rx_load), .rx_byte(rx_byte), .din_full(din_full),
        .tx_take(tx_take), .dout_byte(dout_byte), .dout_full(dout_full)
    );

    typedef struct packed {
        logic       cs;
        logic       wr;
        logic       rd;
        logic [2:0] sel;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // sticky-mode walk: {cs, wr, rd, sel, wdata, check, expected rdata, req}
    localparam vec_t TBL [23] = '{
        '{1'b1,1'b1,1'b0,3'd1,8'h11,1'b0,8'h00,4'd1},  // R1 store offset 1
        '{1'b1,1'b0,1'b1,3'd1,8'h00,1'b1,8'h11,4'd1},  // R1 read back
        '{1'b1,1'b1,1'b0,3'd2,8'h22,1'b0,8'h00,4'd1},  // R1 unpaged offset 2
        '{1'b1,1'b0,1'b1,3'd2,8'h00,1'b1,8'h22,4'd1},
        '{1'b1,1'b1,1'b0,3'd3,8'h51,1'b0,8'h00,4'd3},  // R3 page in 1
        '{1'b1,1'b0,1'b1,3'd3,8'h00,1'b1,8'h51,4'd12}, // R12 last command
        '{1'b1,1'b0,1'b1,3'd2,8'h00,1'b1,8'h00,4'd3},  // R3 page 1 at offset 2
        '{1'b1,1'b1,1'b0,3'd2,8'hA1,1'b0,8'h00,4'd3},
        '{1'b1,1'b1,1'b0,3'd3,8'h50,1'b0,8'h00,4'd3},  // R3 page in 0
        '{1'b1,1'b0,1'b1,3'd2,8'h00,1'b1,8'h00,4'd3},
        '{1'b1,1'b1,1'b0,3'd2,8'hB0,1'b0,8'h00,4'd3},
        '{1'b1,1'b1,1'b0,3'd1,8'h33,1'b0,8'h00,4'd4},  // R4 other access
        '{1'b1,1'b0,1'b1,3'd2,8'h00,1'b1,8'hB0,4'd4},  // R4 still page 0
        '{1'b1,1'b1,1'b0,3'd3,8'h51,1'b0,8'h00,4'd4},  // R4 replaced
        '{1'b1,1'b0,1'b1,3'd2,8'h00,1'b1,8'hA1,4'd4},
        '{1'b0,1'b1,1'b0,3'd1,8'hEE,1'b0,8'h00,4'd9},  // R9 cs low write
        '{1'b1,1'b0,1'b1,3'd1,8'h00,1'b1,8'h33,4'd9},
        '{1'b1,1'b1,1'b1,3'd4,8'h44,1'b1,8'h33,4'd11}, // R11 write wins
        '{1'b1,1'b0,1'b1,3'd4,8'h00,1'b1,8'h44,4'd11},
        '{1'b1,1'b0,1'b1,3'd7,8'h00,1'b1,8'h00,4'd1},
        '{1'b1,1'b1,1'b0,3'd3,8'h07,1'b0,8'h00,4'd12}, // R12 plain command
        '{1'b1,1'b0,1'b1,3'd2,8'h00,1'b1,8'hA1,4'd4},
        '{1'b1,1'b0,1'b1,3'd3,8'h00,1'b1,8'h07,4'd12}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic w, input logic r, input logic g,
                       input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        cs = c; wr_en = w; rd_en = r; dma_gnt = g; reg_sel = s; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, s, d);
    endtask

    task automatic rd(input logic [2:0] s);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, s, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 rdata in reset", rdata, 8'h00);
        chk("R10 dma_req in reset", {7'd0, dma_req}, 8'h00);
        chk("R10 dout_full in reset", {7'd0, dout_full}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        chk("R8 request with empty data-out", {7'd0, dma_req}, 8'h01);

        for (int i = 0; i < 23; i++) begin
            cyc(TBL[i].cs, TBL[i].wr, TBL[i].rd, 1'b0, TBL[i].sel, TBL[i].wd);
            if (TBL[i].chk) begin
                checks++;
                if (rdata !== TBL[i].exp) begin
                    errors++;
                    $display("FAIL R%0d row %0d: actual %02h expected %02h",
                             TBL[i].req, i, rdata, TBL[i].exp);
                end
            end
        end

        // R13 and R2: load, then read colliding with a new load
        rx_byte = 8'hC3; rx_load = 1'b1;
        idle();
        rx_load = 1'b0;
        chk("R13 din_full after load", {7'd0, din_full}, 8'h01);
        rx_byte = 8'h3C; rx_load = 1'b1;
        rd(3'd0);
        rx_load = 1'b0;
        chk("R13 read returns old byte", rdata, 8'hC3);
        chk("R13 din_full kept", {7'd0, din_full}, 8'h01);
        rd(3'd0);
        chk("R2 read of data-in", rdata, 8'h3C);
        chk("R2 din_full cleared", {7'd0, din_full}, 8'h00);

        wr(3'd0, 8'h5D);
        chk("R2 data-out byte", dout_byte, 8'h5D);
        chk("R2 dout_full set", {7'd0, dout_full}, 8'h01);
        chk("R8 no request when nothing to move", {7'd0, dma_req}, 8'h00);
        tx_take = 1'b1;
        idle();
        tx_take = 1'b0;
        chk("R13 take clears dout_full", {7'd0, dout_full}, 8'h00);
        chk("R8 request after take", {7'd0, dma_req}, 8'h01);

        // R6 DMA write ignores select
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 8'h6E);
        chk("R6 DMA write to data-out", dout_byte, 8'h6E);
        chk("R8 request drops after grant", {7'd0, dma_req}, 8'h00);
        rd(3'd1);
        chk("R6 offset 1 untouched by DMA", rdata, 8'h33);
        tx_take = 1'b1;
        idle();
        tx_take = 1'b0;

        // R6 DMA read, inverted strobe
        rx_byte = 8'h7A; rx_load = 1'b1;
        idle();
        rx_load = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 8'h00);
        chk("R6 DMA read of data-in", rdata, 8'h7A);
        chk("R6 DMA read clears din_full", {7'd0, din_full}, 8'h00);
        chk("R8 low after grant read", {7'd0, dma_req}, 8'h00);
        idle();
        chk("R8 request returns", {7'd0, dma_req}, 8'h01);

        // R7 grant with read strobe high is no access
        rx_byte = 8'h11; rx_load = 1'b1;
        idle();
        rx_load = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00);
        chk("R7 rdata unchanged", rdata, 8'h7A);
        chk("R7 din_full unchanged", {7'd0, din_full}, 8'h01);
        rd(3'd0);

        // R5 one-shot window
        page_mode = 1'b1;
        wr(3'd3, 8'h52);
        wr(3'd5, 8'h9C);
        rd(3'd5);
        chk("R5 window closed after one access", rdata, 8'h00);
        rd(3'd2);
        chk("R3 one-shot command keeps offset 2 map", rdata, 8'h9C);
        wr(3'd3, 8'h50);
        rd(3'd5);
        chk("R5 window read page 1", rdata, 8'h9C);
        rd(3'd5);
        chk("R5 base offset 5 after window", rdata, 8'h00);
        wr(3'd3, 8'h50);
        rd(3'd1);
        rd(3'd4);
        chk("R5 window closed by other offset", rdata, 8'h44);
        wr(3'd3, 8'h50);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 8'hFF);
        rd(3'd4);
        chk("R9 idle cycle keeps window", rdata, 8'hB0);
        wr(3'd3, 8'h50);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 8'h12);
        rd(3'd4);
        chk("R5 DMA cycle keeps window", rdata, 8'hB0);

        // R10 reset mid-run
        page_mode = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R10 rdata cleared", rdata, 8'h00);
        chk("R10 dma_req cleared", {7'd0, dma_req}, 8'h00);
        chk("R10 din_full cleared", {7'd0, din_full}, 8'h00);
        chk("R10 dout_full cleared", {7'd0, dout_full}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        wr(3'd2, 8'h5A);
        rd(3'd2);
        chk("R10 offset 2 unpaged after reset", rdata, 8'h5A);
        wr(3'd3, 8'h51);
        rd(3'd2);
        chk("R10 page bank cleared", rdata, 8'h00);
        rd(3'd1);
        chk("R10 storage cleared", rdata, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule